// File: doc/BRIEF.md
# Differential Synapse Update Sequencer

This block applies one learning step to a binary synapse built from two resistive devices, a primary cell and its complement. The sign of the stored weight is never measured as a value. It is taken from a differential sense comparison returned by the array: the weight is +1 when the primary cell is the more resistive of the pair, and -1 otherwise. A learning engine hands the block an address and a direction. The block then drives an external array driver with timed pulse commands and tells the engine when the step is complete.

With verification enabled, a step has three parts. The block reads and latches the sign. It applies one weak RESET pulse to the device picked by the direction. It then reads the sign again. If the second read disagrees with the first, the pair has crossed over and is close to saturating. The block then SETs both devices fully and applies one weak RESET that encodes the new sign again, which restores programming headroom without any periodic refresh. With verification disabled, a step is only the single weak RESET pulse. Pulse widths come from two length inputs counted in clock cycles. At 100 MHz, 10 cycles gives a 100 ns weak RESET and 100 cycles gives 1 µs.

Top module: `syn_update_seq`

## Requirements
- R1: After reset the block is idle: reqReady is 1, and busy, done, cmdValid and flipRecovered are 0.
- R2: A step is accepted only in a cycle where reqValid and reqReady are both 1. reqReady stays 0 from that acceptance until the step finishes, and requests presented during that time are ignored.
- R3: With cfgVerify=1, a step issues SENSE (cmdCode 4'b0001), then one weak RESET, then a second SENSE. The weak RESET is on the primary cell (4'b0010) when reqDir=1 (increase) and on the complement (4'b0100) when reqDir=0 (decrease).
- R4: After each SENSE command, cmdValid stays 0 until senseValid has returned a result.
- R5: Every pulse command holds cmdValid high with a constant cmdCode for exactly cfgWresetLen cycles (weak RESET) or cfgSetLen cycles (SET_BOTH, 4'b1000). A length of 0 counts as 1. A SENSE command lasts one cycle.
- R6: If the second sense (senseBit, where 1 means +1) differs from the first, SET_BOTH follows the second SENSE. It is followed by a weak RESET on the primary cell when the new sense was 1, and on the complement when it was 0.
- R7: If the two senses agree, no further command is issued after the second SENSE.
- R8: With cfgVerify=0, the step is only the one weak RESET chosen by reqDir, with no SENSE and no recovery.
- R9: done is a one-cycle pulse after the last command of a step. From the next cycle, flipRecovered shows whether recovery ran in that step, and it holds that value until the next done.
- R10: cmdAddr equals the accepted reqAddr on every command of the step, and cmdCode is one-hot whenever cmdValid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Update request present |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqAddr | input | ADDR_W | Synapse address of the request |
| reqDir | input | 1 | 1 = increase weight, 0 = decrease |
| cfgVerify | input | 1 | 1 = pre-read, verify read and recovery enabled |
| cfgWresetLen | input | CNT_W | Weak RESET width in cycles |
| cfgSetLen | input | CNT_W | Full SET width in cycles |
| cmdValid | output | 1 | Array command active |
| cmdCode | output | 4 | One-hot command: bit0 SENSE, bit1 weak RESET primary, bit2 weak RESET complement, bit3 SET both |
| cmdAddr | output | ADDR_W | Synapse address for the command |
| senseValid | input | 1 | Sense result strobe |
| senseBit | input | 1 | Sensed sign, 1 = +1 |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle end-of-step pulse |
| flipRecovered | output | 1 | Last step ran the recovery sequence |

## Verification
Some properties are checked on every cycle: cmdCode is one-hot, cmdValid is silent after a SENSE, done lasts one cycle, cmdAddr is stable across a command, the idle port state is quiet, and flipRecovered moves only at the end of a step. Other behaviour can only be shown by the bench's scenarios, which run a two-conductance device model. These are the full command order, the exact pulse widths including the zero-length case, whether recovery happens and which side it targets, and the outcome of each step for both directions with verification on and off.

// File: rtl/syn_seq_pkg.sv
package syn_seq_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_NONE  = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_SENSE = 4'b0001;
  localparam logic [CMD_W-1:0] CMD_WRPRI = 4'b0010;
  localparam logic [CMD_W-1:0] CMD_WRCMP = 4'b0100;
  localparam logic [CMD_W-1:0] CMD_SETB  = 4'b1000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE_SENSE, ST_PRE_WAIT, ST_PULSE, ST_POST_SENSE,
    ST_POST_WAIT, ST_REC_SET, ST_REC_WRES, ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // capture request fields
    logic latchPre;  // capture first sense
    logic latchPost; // capture second sense
    logic loadCnt;   // load pulse counter
    logic selSet;    // counter source: SET width
    logic decCnt;    // count down
    logic finish;    // publish flip status
  } dpStrobe_t;
endpackage

// File: rtl/syn_seq_dpath.sv
module syn_seq_dpath
  import syn_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDir,
  input  logic              senseBit,
  input  logic [CNT_W-1:0]  cfgWresetLen,
  input  logic [CNT_W-1:0]  cfgSetLen,
  output logic [ADDR_W-1:0] addrQ,
  output logic              dirQ,
  output logic              newW,
  output logic              flipDiff,
  output logic              cntZero,
  output logic              flipRecovered
);
  logic             preW;
  logic             flipQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenSel;

  assign lenSel   = stb.selSet ? cfgSetLen : cfgWresetLen;
  assign cntZero  = (cnt == '0);
  assign flipDiff = senseBit ^ preW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ         <= '0;
      dirQ          <= 1'b0;
      preW          <= 1'b0;
      newW          <= 1'b0;
      flipQ         <= 1'b0;
      flipRecovered <= 1'b0;
      cnt           <= '0;
    end else begin
      if (stb.accept) begin
        addrQ <= reqAddr;
        dirQ  <= reqDir;
        flipQ <= 1'b0;
      end
      if (stb.latchPre) preW <= senseBit;
      if (stb.latchPost) begin
        newW  <= senseBit;
        flipQ <= senseBit ^ preW;
      end
      if (stb.finish) flipRecovered <= flipQ;
      if (stb.loadCnt)
        cnt <= (lenSel == '0) ? '0 : lenSel - 1'b1;
      else if (stb.decCnt && !cntZero)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/syn_seq_ctrl.sv
module syn_seq_ctrl
  import syn_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             cfgVerify,
  input  logic             senseValid,
  input  logic             flipDiff,
  input  logic             dirQ,
  input  logic             newW,
  input  logic             cntZero,
  output dpStrobe_t        stb,
  output logic             reqReady,
  output logic             busy,
  output logic             done,
  output logic             cmdValid,
  output logic [CMD_W-1:0] cmdCode
);
  seqState_t state, nextState;
  logic verifyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      verifyQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && reqValid) verifyQ <= cfgVerify;
    end
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stb.accept = 1'b1;
        if (cfgVerify) nextState = ST_PRE_SENSE;
        else begin
          nextState   = ST_PULSE;
          stb.loadCnt = 1'b1;
        end
      end
      ST_PRE_SENSE: nextState = ST_PRE_WAIT;
      ST_PRE_WAIT: if (senseValid) begin
        stb.latchPre = 1'b1;
        stb.loadCnt  = 1'b1;
        nextState    = ST_PULSE;
      end
      ST_PULSE: begin
        if (cntZero) nextState = verifyQ ? ST_POST_SENSE : ST_FINISH;
        else stb.decCnt = 1'b1;
      end
      ST_POST_SENSE: nextState = ST_POST_WAIT;
      ST_POST_WAIT: if (senseValid) begin
        stb.latchPost = 1'b1;
        if (flipDiff) begin
          nextState   = ST_REC_SET;
          stb.loadCnt = 1'b1;
          stb.selSet  = 1'b1;
        end else nextState = ST_FINISH;
      end
      ST_REC_SET: begin
        if (cntZero) begin
          nextState   = ST_REC_WRES;
          stb.loadCnt = 1'b1;
        end else stb.decCnt = 1'b1;
      end
      ST_REC_WRES: begin
        if (cntZero) nextState = ST_FINISH;
        else stb.decCnt = 1'b1;
      end
      ST_FINISH: begin
        stb.finish = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_PRE_SENSE, ST_POST_SENSE: cmdCode = CMD_SENSE;
      ST_PULSE:    cmdCode = dirQ ? CMD_WRPRI : CMD_WRCMP;
      ST_REC_SET:  cmdCode = CMD_SETB;
      ST_REC_WRES: cmdCode = newW ? CMD_WRPRI : CMD_WRCMP;
      default:     cmdCode = CMD_NONE;
    endcase
  end

  assign cmdValid = (cmdCode != CMD_NONE);
  assign reqReady = (state == ST_IDLE);
  assign busy     = !reqReady;
  assign done     = (state == ST_FINISH);
endmodule

// File: rtl/syn_update_seq.sv
module syn_update_seq
  import syn_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDir,
  input  logic              cfgVerify,
  input  logic [CNT_W-1:0]  cfgWresetLen,
  input  logic [CNT_W-1:0]  cfgSetLen,
  output logic              cmdValid,
  output logic [3:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  input  logic              senseValid,
  input  logic              senseBit,
  output logic              busy,
  output logic              done,
  output logic              flipRecovered
);
  dpStrobe_t stb;
  logic dirQ, newW, flipDiff, cntZero;

  syn_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgVerify(cfgVerify),
    .senseValid(senseValid), .flipDiff(flipDiff), .dirQ(dirQ), .newW(newW),
    .cntZero(cntZero), .stb(stb), .reqReady(reqReady), .busy(busy),
    .done(done), .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  syn_seq_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqDir(reqDir),
    .senseBit(senseBit), .cfgWresetLen(cfgWresetLen), .cfgSetLen(cfgSetLen),
    .addrQ(cmdAddr), .dirQ(dirQ), .newW(newW), .flipDiff(flipDiff),
    .cntZero(cntZero), .flipRecovered(flipRecovered)
  );
endmodule

// File: rtl/syn_update_seq_chk.sv
module syn_update_seq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              cmdValid,
  input logic [3:0]        cmdCode,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              busy,
  input logic              done,
  input logic              flipRecovered
);
  p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $countones(cmdCode) == 1);

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |=> (!cmdValid || $stable(cmdAddr)));

  p_sense_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 4'b0001) |=> !cmdValid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  p_flip_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(flipRecovered));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!cmdValid && !done));
endmodule

bind syn_update_seq syn_update_seq_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdAddr(cmdAddr), .busy(busy),
  .done(done), .flipRecovered(flipRecovered)
);

// File: tb/tb_syn_update_seq.sv
module tb_syn_update_seq;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 8;
  localparam int GMAX   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqDir = 1'b0, cfgVerify = 1'b1;
  logic [ADDR_W-1:0] reqAddr = '0, cmdAddr;
  logic [CNT_W-1:0] cfgWresetLen = 8'd10, cfgSetLen = 8'd4;
  logic cmdValid, senseValid = 1'b0, senseBit = 1'b0, busy, done, flipRecovered;
  logic [3:0] cmdCode;

  always #5 clk = ~clk;

  syn_update_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqDir(reqDir), .cfgVerify(cfgVerify),
    .cfgWresetLen(cfgWresetLen), .cfgSetLen(cfgSetLen), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdAddr(cmdAddr), .senseValid(senseValid),
    .senseBit(senseBit), .busy(busy), .done(done), .flipRecovered(flipRecovered)
  );

  int nChk = 0, nFail = 0;
  int gPri = GMAX, gCmp = GMAX;      // device conductances
  int stepPri = 3, stepCmp = 3;
  logic [ADDR_W-1:0] curAddr = '0;
  int recN = 0;
  logic [3:0] recCode [16];
  int recLen [16];
  logic prevValid = 1'b0;
  logic [3:0] prevCode = '0;
  int senseDly = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit signOf(input int p, input int c);
    return p < c;   // primary more resistive (lower conductance) -> +1
  endfunction

  function automatic int sub0(input int g, input int s);
    return (g > s) ? g - s : 0;
  endfunction

  function automatic int eff(input int len);
    return (len == 0) ? 1 : len;
  endfunction

  // array / device model and command monitor
  always @(negedge clk) begin
    if (rstN) begin
      senseValid <= 1'b0;
      if (senseDly > 0) begin
        if (cmdValid) chk(1'b0, "R4 command while sense pending", int'(cmdCode), 0);
        senseDly = senseDly - 1;
        if (senseDly == 0) begin
          senseValid <= 1'b1;
          senseBit   <= signOf(gPri, gCmp);
        end
      end
      if (cmdValid) begin
        if (cmdAddr !== curAddr) chk(1'b0, "R10 cmdAddr", int'(cmdAddr), int'(curAddr));
        if (!prevValid || cmdCode != prevCode) begin
          if (recN < 16) begin
            recCode[recN] = cmdCode;
            recLen[recN]  = 1;
          end
          recN++;
          case (cmdCode)
            4'b0010: gPri = sub0(gPri, stepPri);
            4'b0100: gCmp = sub0(gCmp, stepCmp);
            4'b1000: begin gPri = GMAX; gCmp = GMAX; end
            4'b0001: senseDly = 1 + int'($urandom % 3);
            default: ;
          endcase
        end else if (recN > 0 && recN <= 16) recLen[recN-1]++;
      end
      prevValid = cmdValid;
      prevCode  = cmdCode;
    end
  end

  task automatic doUpdate(input bit dir, input bit ver, input int wl, input int sl);
    logic [3:0] eCode [8];
    int eLen [8];
    int eN = 0;
    int p = gPri, c = gCmp;
    bit pre, post, eFlip = 0;
    bit hold = ver;
    int guard = 0;
    @(negedge clk);
    cfgVerify = ver; cfgWresetLen = CNT_W'(wl); cfgSetLen = CNT_W'(sl);
    pre = signOf(p, c);
    if (ver) begin eCode[eN] = 4'b0001; eLen[eN] = 1; eN++; end
    eCode[eN] = dir ? 4'b0010 : 4'b0100; eLen[eN] = eff(wl); eN++;
    if (dir) p = sub0(p, stepPri); else c = sub0(c, stepCmp);
    if (ver) begin
      eCode[eN] = 4'b0001; eLen[eN] = 1; eN++;
      post = signOf(p, c);
      if (post != pre) begin
        eFlip = 1;
        eCode[eN] = 4'b1000; eLen[eN] = eff(sl); eN++;
        eCode[eN] = post ? 4'b0010 : 4'b0100; eLen[eN] = eff(wl); eN++;
      end
    end
    recN = 0;
    chk(reqReady == 1'b1, "R2 ready before request", int'(reqReady), 1);
    curAddr = ADDR_W'($urandom);
    reqAddr = curAddr; reqDir = dir; reqValid = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b0, "R2 ready dropped after accept", int'(reqReady), 0);
    if (hold) begin
      // requests while busy must be ignored (R2); address checked by monitor
      reqAddr = ~curAddr; reqDir = ~dir;
      @(negedge clk);
      chk(reqReady == 1'b0, "R2 held off while busy", int'(reqReady), 0);
    end
    reqValid = 1'b0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk(reqReady == 1'b1, "R2 ready after step", int'(reqReady), 1);
    chk(flipRecovered == eFlip, "R9 R6 flipRecovered", int'(flipRecovered), int'(eFlip));
    chk(recN == eN, ver ? (eFlip ? "R6 command count" : "R7 command count")
                        : "R8 command count", recN, eN);
    for (int i = 0; i < eN && i < recN && i < 16; i++) begin
      chk(recCode[i] == eCode[i], ver ? "R3 R6 command order" : "R8 command code",
          int'(recCode[i]), int'(eCode[i]));
      chk(recLen[i] == eLen[i], "R5 pulse width", recLen[i], eLen[i]);
    end
    if (eFlip) chk(signOf(gPri, gCmp) == post, "R6 sign kept after recovery",
                   int'(signOf(gPri, gCmp)), int'(post));
  endtask

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(cmdValid == 1'b0, "R1 cmdValid", int'(cmdValid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(flipRecovered == 1'b0, "R1 flipRecovered", int'(flipRecovered), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && busy == 1'b0, "R1 idle after reset", int'(busy), 0);
    // directed: tie -> increase flips to +1 (R6 recovery on primary)
    doUpdate(1'b1, 1'b1, 10, 4);
    // decrease flips back to -1 (R6 recovery on complement)
    stepCmp = 5;
    doUpdate(1'b0, 1'b1, 10, 4);
    // no flip, verify on (R7), zero widths (R5)
    doUpdate(1'b0, 1'b1, 0, 0);
    // verify off (R8), long pulse
    doUpdate(1'b1, 1'b0, 100, 3);
    doUpdate(1'b0, 1'b0, 1, 1);
    for (int k = 0; k < 80; k++) begin
      stepPri = 1 + int'($urandom % 4);
      stepCmp = 1 + int'($urandom % 4);
      if ($urandom % 10 == 0) begin gPri = GMAX; gCmp = GMAX; end
      doUpdate(1'($urandom), ($urandom % 5) != 0, int'($urandom % 13), int'($urandom % 7));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule